// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Controller

The controller connects a synchronous request port to an asynchronous 4-bit EDO DRAM with a multiplexed address bus. Each request carries a 24-bit word address, a direction flag and a 4-bit write datum. The controller splits the address into a 13-bit row and an 11-bit column. It sequences the row strobe, column strobe, write enable and output enable, and drives the data pins through an output-enable signal. Read data is captured from the EDO output while that output is still held after the column strobe rises. The captured data comes back as a registered word with a one-cycle valid pulse.

While requests keep hitting the open row, the controller keeps the row strobe low and cycles only the column strobe (page mode). It closes the row and precharges when a request names another row, when a refresh is requested, or before the row strobe would exceed its maximum low time. A separate scheduler asks for refresh through a request/grant pair. The controller answers with a column-before-row refresh cycle. Every timing limit is a parameter counted in system clock cycles.

Top module: `edo_page_ctrl`

## Requirements
- R1: The word address splits as row = addr[23:11] and column = addr[10:0]. The row is on dram_addr when the row strobe falls. The column is on dram_addr[10:0], with dram_addr[12:11] = 0, when the column strobe falls for an access.
- R2: The row strobe stays low for at least T_RAS_MIN and at most T_RAS_MAX cycles. An idle open row is closed by that limit.
- R3: The row strobe stays high for at least T_RP cycles between low periods. Its falling edges are at least T_RC cycles apart.
- R4: The first column strobe fall comes at least T_RCD cycles after the row strobe falls. The row address is still on the bus one cycle after the row strobe falls. The column address is on the bus in the cycle before the column strobe falls and stays stable while the column strobe is low.
- R5: The column strobe stays low for at least T_CAS cycles. Between page accesses it stays high for at least T_CP cycles.
- R6: Consecutive requests to the open row are served in one row-strobe low period, with one column strobe cycle each.
- R7: A request to a row other than the open one closes the row, precharges, and opens the new row. Data stays correct across the switch.
- R8: A write drives dram_we_n low at least one cycle before the column strobe falls. The datum is driven with dram_dq_oe = 1 at that edge. A read keeps dram_we_n high and dram_oe_n low at the column strobe fall.
- R9: Each read returns one rd_valid pulse of one cycle, in request order. The data is the last word written to that address, or the memory's prior content.
- R10: ref_gnt pulses for one cycle when the column strobe falls with the row strobe high. The row strobe then falls while the column strobe is low, with dram_we_n high. Each grant gives exactly one such refresh.
- R11: During reset, all four strobes are high, dram_dq_oe, rd_valid, ref_gnt and busy are 0.
- R12: busy is 1 whenever the row or column strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Word address (row in upper 13 bits) |
| req_wdata | input | 4 | Write datum |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 4 | Captured read data |
| busy | output | 1 | Controller away from idle |
| ref_req | input | 1 | Refresh request from scheduler |
| ref_gnt | output | 1 | Refresh accepted pulse |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 13 | Multiplexed row/column address |
| dram_dq_o | output | 4 | Data toward memory |
| dram_dq_oe | output | 1 | Drive enable for data pins |
| dram_dq_i | input | 4 | Data from memory |

## Verification
A same-row burst of reads shows whether page hits stay inside one row period. Alternating rows with writes and reads shows whether misses close and reopen correctly and whether data survives the switch. A long same-row burst and a quiet spell force the maximum-low-time close, which ordinary traffic never reaches. Seeded random traffic over a few rows, with refresh requests arriving at arbitrary times, mixes hits, misses and refresh preemption. A bench memory model checks every strobe width and every transferred word.

// File: rtl/edo_pkg.sv
`timescale 1ns/1ps
package edo_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_CASL,
        ST_OPEN,
        ST_REFC,
        ST_REFR
    } st_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/edo_span_ctr.sv
`timescale 1ns/1ps
module edo_span_ctr #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt_q
);
    logic [W-1:0] cnt_d;

    always_comb begin
        if (clr)          cnt_d = '0;
        else if (&cnt_q)  cnt_d = cnt_q;
        else              cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '1;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/edo_addr_split.sv
`timescale 1ns/1ps
module edo_addr_split #(
    parameter int ROW_W = 13,
    parameter int COL_W = 11,
    parameter int BUS_W = 13,
    localparam int AW   = ROW_W + COL_W
) (
    input  logic [AW-1:0]    addr,
    input  logic [ROW_W-1:0] open_row,
    output logic [ROW_W-1:0] row,
    output logic [BUS_W-1:0] col_bus,
    output logic             hit
);
    assign row = addr[AW-1:COL_W];
    assign hit = (row == open_row);

    generate
        if (BUS_W > COL_W) begin : g_pad
            assign col_bus = {{(BUS_W-COL_W){1'b0}}, addr[COL_W-1:0]};
        end else begin : g_nopad
            assign col_bus = addr[COL_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/edo_page_ctrl.sv
`timescale 1ns/1ps
module edo_page_ctrl
    import edo_pkg::*;
#(
    parameter int ROW_W     = 13,
    parameter int COL_W     = 11,
    parameter int DQ_W      = 4,
    parameter int T_RAS_MIN = 13,
    parameter int T_RAS_MAX = 2500,
    parameter int T_RP      = 8,
    parameter int T_RC      = 21,
    parameter int T_RCD     = 4,
    parameter int T_CAS     = 4,
    parameter int T_CP      = 2,
    localparam int AW       = ROW_W + COL_W,
    localparam int BUS_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DQ_W-1:0]  req_wdata,
    output logic             rd_valid,
    output logic [DQ_W-1:0]  rd_data,
    output logic             busy,
    input  logic             ref_req,
    output logic             ref_gnt,
    output logic             dram_ras_n,
    output logic             dram_cas_n,
    output logic             dram_we_n,
    output logic             dram_oe_n,
    output logic [BUS_W-1:0] dram_addr,
    output logic [DQ_W-1:0]  dram_dq_o,
    output logic             dram_dq_oe,
    input  logic [DQ_W-1:0]  dram_dq_i
);
    // Derived sizes and limits
    localparam int CTR_W    = $clog2(T_RAS_MAX + T_RC + 4) + 1;
    localparam int PH_W     = $clog2(max3(T_RCD, T_CAS, T_CP) + 1) + 1;
    localparam int CLOSE_AT = T_RAS_MAX - T_CAS - 2;

    localparam logic [CTR_W-1:0] LIM_RASMIN = CTR_W'(T_RAS_MIN - 1);
    localparam logic [CTR_W-1:0] LIM_RASMAX = CTR_W'(T_RAS_MAX);
    localparam logic [CTR_W-1:0] LIM_RP     = CTR_W'(T_RP - 1);
    localparam logic [CTR_W-1:0] LIM_RC     = CTR_W'(T_RC - 1);
    localparam logic [CTR_W-1:0] LIM_CLOSE  = CTR_W'(CLOSE_AT);

    typedef struct packed {
        st_e              st;
        logic             ras_n;
        logic             cas_n;
        logic             we_n;
        logic             oe_n;
        logic [BUS_W-1:0] addr;
        logic [DQ_W-1:0]  dq;
        logic             dq_oe;
        logic [ROW_W-1:0] row;
        logic [BUS_W-1:0] colb;
        logic             wr;
        logic             cap;
        logic [PH_W-1:0]  cnt;
        logic             rd_v;
        logic [DQ_W-1:0]  rd_d;
        logic             gnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // Elapsed-time counters: since row strobe fell / since it rose
    logic [CTR_W-1:0] act_q, pre_q;
    logic             clr_act, clr_pre;

    assign clr_act = ctl_q.ras_n & ~ctl_d.ras_n;
    assign clr_pre = ~ctl_q.ras_n & ctl_d.ras_n;

    edo_span_ctr #(.W(CTR_W)) u_act (
        .clk(clk), .rst_n(rst_n), .clr(clr_act), .cnt_q(act_q)
    );
    edo_span_ctr #(.W(CTR_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(clr_pre), .cnt_q(pre_q)
    );

    // Address decode against the open row
    logic [ROW_W-1:0] req_row;
    logic [BUS_W-1:0] req_colb;
    logic             req_hit;

    edo_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W), .BUS_W(BUS_W)) u_split (
        .addr(req_addr), .open_row(ctl_q.row),
        .row(req_row), .col_bus(req_colb), .hit(req_hit)
    );

    logic ready_c;
    logic close_need;
    logic room_ok;

    assign room_ok = (act_q < LIM_CLOSE);

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.rd_v = 1'b0;
        ctl_d.gnt  = 1'b0;
        ready_c    = 1'b0;
        close_need = 1'b0;

        // EDO capture: one cycle after the column strobe has risen
        if (ctl_q.st == ST_OPEN && ctl_q.cap) begin
            ctl_d.rd_v = 1'b1;
            ctl_d.rd_d = dram_dq_i;
            ctl_d.cap  = 1'b0;
        end

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (pre_q >= LIM_RP && act_q >= LIM_RC) begin
                    if (ref_req) begin
                        ctl_d.st    = ST_REFC;
                        ctl_d.cas_n = 1'b0;
                        ctl_d.gnt   = 1'b1;
                    end else begin
                        ready_c = 1'b1;
                        if (req_valid) begin
                            ctl_d.st    = ST_LEAD;
                            ctl_d.ras_n = 1'b0;
                            ctl_d.addr  = BUS_W'(req_row);
                            ctl_d.row   = req_row;
                            ctl_d.colb  = req_colb;
                            ctl_d.wr    = req_write;
                            ctl_d.we_n  = ~req_write;
                            ctl_d.oe_n  = 1'b1;
                            ctl_d.dq    = req_wdata;
                            ctl_d.dq_oe = req_write;
                            ctl_d.cnt   = PH_W'(T_RCD - 1);
                        end
                    end
                end
            end
            ST_LEAD: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.st    = ST_CASL;
                    ctl_d.cas_n = 1'b0;
                    ctl_d.oe_n  = ctl_q.wr;
                    ctl_d.cnt   = PH_W'(T_CAS - 1);
                end else begin
                    ctl_d.cnt = ctl_q.cnt - PH_W'(1);
                    if (ctl_q.cnt == PH_W'(1)) ctl_d.addr = ctl_q.colb;
                end
            end
            ST_CASL: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.st    = ST_OPEN;
                    ctl_d.cas_n = 1'b1;
                    ctl_d.cap   = ~ctl_q.wr;
                    ctl_d.we_n  = 1'b1;
                    ctl_d.dq_oe = 1'b0;
                    ctl_d.cnt   = PH_W'(T_CP - 2);
                end else begin
                    ctl_d.cnt = ctl_q.cnt - PH_W'(1);
                end
            end
            ST_OPEN: begin
                if (ctl_q.cnt != '0) ctl_d.cnt = ctl_q.cnt - PH_W'(1);
                close_need = ref_req || !room_ok || (req_valid && !req_hit);
                if (close_need) begin
                    if (act_q >= LIM_RASMIN) begin
                        ctl_d.st    = ST_IDLE;
                        ctl_d.ras_n = 1'b1;
                        ctl_d.oe_n  = 1'b1;
                    end
                end else if (ctl_q.cnt == '0) begin
                    ready_c = 1'b1;
                    if (req_valid) begin
                        ctl_d.st    = ST_LEAD;
                        ctl_d.addr  = req_colb;
                        ctl_d.colb  = req_colb;
                        ctl_d.wr    = req_write;
                        ctl_d.we_n  = ~req_write;
                        ctl_d.oe_n  = req_write ? 1'b1 : ctl_q.oe_n;
                        ctl_d.dq    = req_wdata;
                        ctl_d.dq_oe = req_write;
                        ctl_d.cnt   = '0;
                    end
                end
            end
            ST_REFC: begin
                ctl_d.st    = ST_REFR;
                ctl_d.ras_n = 1'b0;
            end
            ST_REFR: begin
                if (act_q >= LIM_RASMIN) begin
                    ctl_d.st    = ST_IDLE;
                    ctl_d.ras_n = 1'b1;
                    ctl_d.cas_n = 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.st    <= ST_IDLE;
            ctl_q.ras_n <= 1'b1;
            ctl_q.cas_n <= 1'b1;
            ctl_q.we_n  <= 1'b1;
            ctl_q.oe_n  <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready  = ready_c;
    assign rd_valid   = ctl_q.rd_v;
    assign rd_data    = ctl_q.rd_d;
    assign busy       = (ctl_q.st != ST_IDLE);
    assign ref_gnt    = ctl_q.gnt;
    assign dram_ras_n = ctl_q.ras_n;
    assign dram_cas_n = ctl_q.cas_n;
    assign dram_we_n  = ctl_q.we_n;
    assign dram_oe_n  = ctl_q.oe_n;
    assign dram_addr  = ctl_q.addr;
    assign dram_dq_o  = ctl_q.dq;
    assign dram_dq_oe = ctl_q.dq_oe;

    // Timing and protocol checks
    AST_RAS_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras_n) |-> act_q >= CTR_W'(T_RAS_MIN)); // R2
    AST_RAS_LOW_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_ras_n |-> act_q < LIM_RASMAX); // R2
    AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> pre_q >= CTR_W'(T_RP)); // R3
    AST_ROW_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> $past(act_q) >= LIM_RC); // R3
    AST_COL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_cas_n && !$fell(dram_cas_n)) |-> $stable(dram_addr)); // R4
    AST_WE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_we_n) |-> $past(!dram_we_n)); // R8
    AST_WR_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> dram_dq_oe); // R8
    AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R9
    AST_GNT_CBR: assert property (@(posedge clk) disable iff (!rst_n)
        ref_gnt |-> (!dram_cas_n && dram_ras_n)); // R10
    AST_BUSY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_ras_n || !dram_cas_n) |-> busy); // R12
endmodule

// File: tb/tb_edo_page_ctrl.sv
`timescale 1ns/1ps
module tb_edo_page_ctrl;
    localparam int P_RAS_MIN = 13;
    localparam int P_RAS_MAX = 60;
    localparam int P_RP      = 8;
    localparam int P_RC      = 21;
    localparam int P_RCD     = 4;
    localparam int P_CAS     = 3;
    localparam int P_CP      = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [23:0] req_addr = '0;
    logic [3:0]  req_wdata = '0;
    logic        req_ready, rd_valid, busy, ref_gnt;
    logic [3:0]  rd_data;
    logic        ref_req = 1'b0;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [12:0] dram_addr;
    logic [3:0]  dram_dq_o;
    logic [3:0]  dram_dq_i = '0;

    always #2 clk = ~clk;

    edo_page_ctrl #(
        .T_RAS_MIN(P_RAS_MIN), .T_RAS_MAX(P_RAS_MAX), .T_RP(P_RP), .T_RC(P_RC),
        .T_RCD(P_RCD), .T_CAS(P_CAS), .T_CP(P_CP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
        .ref_req(ref_req), .ref_gnt(ref_gnt),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_o(dram_dq_o),
        .dram_dq_oe(dram_dq_oe), .dram_dq_i(dram_dq_i)
    );

    int  tests = 0, fails = 0;
    bit  done = 1'b0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    function automatic logic [3:0] initv(input logic [23:0] a);
        return a[3:0] ^ a[14:11] ^ a[23:20];
    endfunction

    function automatic logic [23:0] mk(input int row, input int col);
        return {13'(row), 11'(col)};
    endfunction

    typedef struct packed {
        logic [23:0] a;
        logic        wr;
        logic [3:0]  d;
    } acc_t;

    acc_t       aq[$];
    logic [3:0] rq[$];
    logic [3:0] shadow [logic [23:0]];
    logic [3:0] mem    [logic [23:0]];

    // Monitor and memory model state
    int   cyc = 0;
    int   t_rf = -1000, t_rr = -1000, t_cf = -1000, t_cr = -1000;
    bit   seen_rf = 1'b0, seen_rr = 1'b0, cbr = 1'b0, first_cas = 1'b0;
    int   ras_falls = 0, cas_falls = 0, refreshes = 0, grants = 0;
    logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1;
    logic [12:0] p_addr = '0;
    logic [12:0] cur_row = '0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            cyc++;
            chk(!(!dram_ras_n || !dram_cas_n) || busy, "R12", "busy with strobe low", busy, 1);
            if (ref_gnt) begin
                grants++;
                chk(!dram_cas_n && dram_ras_n, "R10", "grant at CAS-first edge", dram_cas_n, 0);
            end
            // row strobe falls
            if (p_ras && !dram_ras_n) begin
                if (seen_rr) chk(cyc - t_rr >= P_RP, "R3", "precharge width", cyc - t_rr, P_RP);
                if (seen_rf) chk(cyc - t_rf >= P_RC, "R3", "row cycle", cyc - t_rf, P_RC);
                if (!dram_cas_n) begin
                    cbr = 1'b1; refreshes++;
                    chk(dram_we_n, "R10", "WE high in refresh", dram_we_n, 1);
                end else begin
                    cbr = 1'b0; cur_row = dram_addr;
                end
                first_cas = 1'b1; t_rf = cyc; seen_rf = 1'b1; ras_falls++;
            end
            if (!dram_ras_n && !cbr && cyc == t_rf + 1)
                chk(dram_addr == cur_row, "R4", "row address hold", dram_addr, cur_row);
            // row strobe rises
            if (!p_ras && dram_ras_n) begin
                chk(cyc - t_rf >= P_RAS_MIN, "R2", "RAS low min", cyc - t_rf, P_RAS_MIN);
                chk(cyc - t_rf <= P_RAS_MAX, "R2", "RAS low max", cyc - t_rf, P_RAS_MAX);
                t_rr = cyc; seen_rr = 1'b1;
            end
            // column strobe falls for an access
            if (p_cas && !dram_cas_n && !dram_ras_n) begin
                acc_t e;
                logic [23:0] k;
                cas_falls++;
                if (first_cas) chk(cyc - t_rf >= P_RCD, "R4", "RAS to CAS", cyc - t_rf, P_RCD);
                else           chk(cyc - t_cr >= P_CP, "R5", "CAS high width", cyc - t_cr, P_CP);
                first_cas = 1'b0;
                chk(dram_addr == p_addr, "R4", "column setup", dram_addr, p_addr);
                chk(dram_addr[12:11] == 2'b00, "R1", "column upper bits", dram_addr[12:11], 0);
                k = {cur_row, dram_addr[10:0]};
                if (aq.size() == 0) begin
                    chk(1'b0, "R1", "unexpected access", k, 0);
                end else begin
                    e = aq.pop_front();
                    chk(k == e.a, "R1", "access address", k, e.a);
                    chk(dram_we_n == !e.wr, "R8", "WE level", dram_we_n, !e.wr);
                    if (e.wr) begin
                        chk(!p_we, "R8", "WE before CAS", p_we, 0);
                        chk(dram_dq_oe && dram_dq_o == e.d, "R8", "write data", dram_dq_o, e.d);
                        mem[k] = dram_dq_o;
                    end else begin
                        chk(!dram_oe_n, "R8", "OE low on read", dram_oe_n, 0);
                        dram_dq_i = mem.exists(k) ? mem[k] : initv(k);
                    end
                end
                t_cf = cyc;
            end
            if (!p_cas && dram_cas_n && !cbr) begin
                chk(cyc - t_cf >= P_CAS, "R5", "CAS low width", cyc - t_cf, P_CAS);
                t_cr = cyc;
            end
            if (rd_valid) begin
                if (rq.size() == 0) chk(1'b0, "R9", "unexpected read valid", rd_data, 0);
                else begin
                    logic [3:0] x;
                    x = rq.pop_front();
                    chk(rd_data == x, "R9", "read data", rd_data, x);
                end
            end
            p_ras = dram_ras_n; p_cas = dram_cas_n; p_we = dram_we_n; p_addr = dram_addr;
        end
    end

    task automatic issue(input logic [23:0] a, input bit wr, input logic [3:0] d);
        acc_t e;
        req_valid = 1'b1; req_addr = a; req_write = wr; req_wdata = d;
        forever begin
            #1;
            if (req_ready) break;
            @(negedge clk);
        end
        e.a = a; e.wr = wr; e.d = d;
        aq.push_back(e);
        if (wr) shadow[a] = d;
        else    rq.push_back(shadow.exists(a) ? shadow[a] : initv(a));
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_ref();
        ref_req = 1'b1;
        do @(negedge clk); while (!ref_gnt);
        ref_req = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 3000; i++) begin
            if (aq.size() == 0 && rq.size() == 0) break;
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        done = 1'b1;
        chk(1'b0, "R9", "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        int base_r, base_c, base_f, base_g;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R11", "strobes high", 
            {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
        chk(!dram_dq_oe && !rd_valid && !ref_gnt && !busy, "R11", "outputs idle",
            {dram_dq_oe, rd_valid, ref_gnt, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 same-row burst stays in one row period
        base_r = ras_falls; base_c = cas_falls;
        for (int i = 0; i < 4; i++) issue(mk(5, i + 1), 1'b0, 4'h0);
        drain();
        chk(ras_falls - base_r == 1, "R6", "row opens for hit burst", ras_falls - base_r, 1);
        chk(cas_falls - base_c == 4, "R6", "column cycles in burst", cas_falls - base_c, 4);

        // R7 row switching with writes then reads
        base_r = ras_falls;
        issue(mk(9, 17), 1'b1, 4'hA);
        issue(mk(300, 2), 1'b1, 4'h5);
        issue(mk(9, 17), 1'b0, 4'h0);
        issue(mk(300, 2), 1'b0, 4'h0);
        drain();
        chk(ras_falls - base_r == 4, "R7", "row reopen per miss", ras_falls - base_r, 4);

        // R2 idle row closes by age
        issue(mk(11, 3), 1'b0, 4'h0);
        repeat (100) @(negedge clk);
        chk(!busy && dram_ras_n, "R2", "idle row closed", {busy, dram_ras_n}, 1);

        // R10 refresh while idle
        base_f = refreshes; base_g = grants;
        do_ref();
        repeat (30) @(negedge clk);
        chk(refreshes - base_f == 1, "R10", "one refresh per grant", refreshes - base_f, 1);
        chk(grants - base_g == 1, "R10", "one grant pulse", grants - base_g, 1);

        // R2 long same-row burst forced to reopen
        base_r = ras_falls;
        for (int i = 0; i < 20; i++) issue(mk(8191, 2040 + (i % 8)), (i % 3) == 0, 4'(i));
        drain();
        chk(ras_falls - base_r >= 2, "R2", "max low time splits burst", ras_falls - base_r, 2);

        // Random traffic with concurrent refresh
        fork
            begin
                for (int n = 0; n < 400; n++) begin
                    int rows[4];
                    rows[0] = 0; rows[1] = 77; rows[2] = 4096; rows[3] = 8191;
                    issue(mk(rows[$urandom % 4], $urandom % 16), ($urandom % 2) == 1,
                          4'($urandom));
                    repeat ($urandom % 3) @(negedge clk);
                end
            end
            begin
                for (int n = 0; n < 5; n++) begin
                    repeat (150 + $urandom % 80) @(negedge clk);
                    do_ref();
                end
            end
        join
        drain();
        chk(aq.size() == 0, "R9", "all accesses done", aq.size(), 0);
        chk(rq.size() == 0, "R9", "all reads returned", rq.size(), 0);
        chk(refreshes == grants, "R10", "refresh count matches grants", refreshes, grants);
        done = 1'b1;
        summary();
    end
endmodule